// File: doc/BRIEF.md
# Banked System Register Index Resolver

This block sits in the register-read stage of a processor core. An instruction names a system or general-purpose register by a logical index. Where that register is physically stored depends on the current processor mode, the execution width, the security state and two fields held in other control registers. The resolver takes the logical index and that context and produces the physical storage index that the register file should access. It is purely combinational.

It handles four kinds of indirection. The first picks the general-purpose register bank for each mode in 32-bit state. The second picks the stack pointer for the current exception level. The third picks the saved-status copy for the current mode. The fourth covers shared entries whose target is chosen by a control field, and registers that hold separate secure and non-secure copies. It also flags three conditions: an undefined mode code, a saved-status request from a mode that has none, and an unknown entry in the shared-entry range.

Top module: `sysreg_index_resolver`

## Requirements
- R1: In 32-bit state (`state64_in`=0), general-purpose indices 0..15 map per mode. FIQ (mode 0x11) sends r8..r14 to 0x100+(r-8). IRQ 0x12, SVC 0x13, ABT 0x17, UND 0x1B and MON 0x16 (slots 0..4 in that order) send r13 and r14 to 0x108+2*slot+(r-13). HYP 0x1A sends r13 to 0x112. Every other register and mode maps to its own index.
- R2: With `state64_in`=1, indices 0..15 map to themselves whatever the mode.
- R3: Index 0x20 is the stack-pointer alias. It resolves to 0x118 when `sp_sel_in`=0 and the exception level is not 0. Otherwise it resolves to 0x118+level. The level is 0 for modes 0x00 and 0x10 and for undefined codes. It is 1 for modes 0x04, 0x05, 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F. It is 2 for modes 0x08, 0x09 and 0x1A, and 3 for modes 0x0C, 0x0D and 0x16.
- R4: Index 0x30 (saved status) resolves to 0x120+slot. The slots are: level-1 modes 0x04/0x05 slot 0, level-2 modes 0x08/0x09 slot 1, level-3 modes 0x0C/0x0D slot 2, FIQ 3, IRQ 4, SVC 5, MON 6, ABT 7, HYP 8, UND 9.
- R5: For index 0x30 in modes 0x00, 0x10, 0x1F or any undefined code, the output stays 0x30 and `no_status_out`=1. `no_status_out` is 0 in every other case.
- R6: The shared entries 0x40..0x42 resolve to 0x54+k when `eae_in`=1 and to 0x50+k when it is 0, where k is the offset from 0x40. Entries 0x44..0x46 resolve to 0x5C+k or 0x58+k in the same way. The result is then banked by R8.
- R7: The shared entry 0x48 resolves to 0x61 when `ctr_sel_in`=31 and to 0x60 for any other value.
- R8: Banked parents are 0x50, 0x54, 0x58, 0x5C and every multiple of 4 from 0x80 to 0xFC. A banked parent resolves to parent+2 when secure and to parent+1 otherwise. Secure means `sec_present_in`=1, `top64_in`=0 and `secure_in`=1 all hold.
- R9: Any index 0x40..0x4F other than 0x40-0x42, 0x44-0x46 and 0x48 sets `mutex_err_out`=1 and passes through unchanged. `mutex_err_out` is 0 for all other indices.
- R10: `bad_mode_out` is 1 exactly when `mode_in` is none of the 16 codes 0x00, 0x04, 0x05, 0x08, 0x09, 0x0C, 0x0D, 0x10, 0x11, 0x12, 0x13, 0x16, 0x17, 0x1A, 0x1B, 0x1F.
- R11: Every other index (0x10..0x1F, 0x21..0x2F, 0x31..0x3F, 0x50..0x7F that are not banked parents, non-parent 0x80..0xFF) passes through zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idx_in | input | 8 | Logical register index |
| mode_in | input | 5 | Current processor mode code |
| sp_sel_in | input | 1 | Stack-select bit: 1 uses the current level's stack pointer |
| state64_in | input | 1 | Core runs in 64-bit state |
| sec_present_in | input | 1 | Security extension configured |
| top64_in | input | 1 | Highest exception level runs 64-bit |
| secure_in | input | 1 | Core is in secure state |
| eae_in | input | 1 | Extended-address enable from the translation control register |
| ctr_sel_in | input | 5 | Performance-counter select field |
| phys_out | output | 9 | Physical storage index |
| bad_mode_out | output | 1 | Mode code is undefined |
| no_status_out | output | 1 | Saved-status request in a mode without one |
| mutex_err_out | output | 1 | Unknown entry in the shared-entry range |

## Verification
The block holds no state, so any wrong internal decision shows on `phys_out` or on a flag in the same evaluation. A bad mode slot misplaces a banked general-purpose register or a saved-status copy. A bad level misplaces the stack pointer. A bad secure qualifier shifts a banked register by one. Sweeping every index across all 32 mode codes, and sweeping each control input around its deciding value, exposes every such fault on the first vector that reaches it.

// File: rtl/sri_pkg.sv
package sri_pkg;

  localparam int IDX_W  = 8;
  localparam int PHYS_W = IDX_W + 1;
  localparam int MODE_W = 5;
  localparam int LVL_W  = 2;
  localparam int CSEL_W = 5;
  localparam int GPR_W  = 4;

  // logical index map
  localparam logic [IDX_W-1:0] L_SP_ALIAS = 8'h20;
  localparam logic [IDX_W-1:0] L_STATUS   = 8'h30;
  localparam logic [3:0]       L_SHARED_HI = 4'h4;
  localparam logic [IDX_W-1:0] L_SH_A     = 8'h40;
  localparam logic [IDX_W-1:0] L_SH_B     = 8'h44;
  localparam logic [IDX_W-1:0] L_SH_EVF   = 8'h48;
  localparam logic [IDX_W-1:0] L_REMAP_A  = 8'h50;
  localparam logic [IDX_W-1:0] L_ATTR_A   = 8'h54;
  localparam logic [IDX_W-1:0] L_REMAP_B  = 8'h58;
  localparam logic [IDX_W-1:0] L_ATTR_B   = 8'h5C;
  localparam logic [IDX_W-1:0] L_EVTYPE   = 8'h60;
  localparam logic [IDX_W-1:0] L_CYCFILT  = 8'h61;
  localparam logic [CSEL_W-1:0] CYC_SEL   = 5'd31;

  // physical index map
  localparam logic [PHYS_W-1:0] P_FIQ    = 9'h100;
  localparam logic [PHYS_W-1:0] P_PAIRS  = 9'h108;
  localparam logic [PHYS_W-1:0] P_HYP13  = 9'h112;
  localparam logic [PHYS_W-1:0] P_SP     = 9'h118;
  localparam logic [PHYS_W-1:0] P_STATUS = 9'h120;

  // mode codes
  localparam logic [MODE_W-1:0] M_EL0T = 5'h00;
  localparam logic [MODE_W-1:0] M_EL1T = 5'h04;
  localparam logic [MODE_W-1:0] M_EL1H = 5'h05;
  localparam logic [MODE_W-1:0] M_EL2T = 5'h08;
  localparam logic [MODE_W-1:0] M_EL2H = 5'h09;
  localparam logic [MODE_W-1:0] M_EL3T = 5'h0C;
  localparam logic [MODE_W-1:0] M_EL3H = 5'h0D;
  localparam logic [MODE_W-1:0] M_USR  = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ  = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ  = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC  = 5'h13;
  localparam logic [MODE_W-1:0] M_MON  = 5'h16;
  localparam logic [MODE_W-1:0] M_ABT  = 5'h17;
  localparam logic [MODE_W-1:0] M_HYP  = 5'h1A;
  localparam logic [MODE_W-1:0] M_UND  = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS  = 5'h1F;

  localparam logic [3:0] NO_SLOT = 4'hF;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    case (m)
      M_EL0T, M_EL1T, M_EL1H, M_EL2T, M_EL2H, M_EL3T, M_EL3H,
      M_USR, M_FIQ, M_IRQ, M_SVC, M_MON, M_ABT, M_HYP, M_UND, M_SYS:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] mode_level(input logic [MODE_W-1:0] m);
    case (m)
      M_EL1T, M_EL1H, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 2'd1;
      M_EL2T, M_EL2H, M_HYP:                                    return 2'd2;
      M_EL3T, M_EL3H, M_MON:                                    return 2'd3;
      default:                                                  return 2'd0;
    endcase
  endfunction

  // slot of the r13/r14 pair for modes that bank only those two
  function automatic logic [3:0] pair_slot(input logic [MODE_W-1:0] m);
    case (m)
      M_IRQ:   return 4'd0;
      M_SVC:   return 4'd1;
      M_ABT:   return 4'd2;
      M_UND:   return 4'd3;
      M_MON:   return 4'd4;
      default: return NO_SLOT;
    endcase
  endfunction

  function automatic logic [3:0] status_slot(input logic [MODE_W-1:0] m);
    case (m)
      M_EL1T, M_EL1H: return 4'd0;
      M_EL2T, M_EL2H: return 4'd1;
      M_EL3T, M_EL3H: return 4'd2;
      M_FIQ:          return 4'd3;
      M_IRQ:          return 4'd4;
      M_SVC:          return 4'd5;
      M_MON:          return 4'd6;
      M_ABT:          return 4'd7;
      M_HYP:          return 4'd8;
      M_UND:          return 4'd9;
      default:        return NO_SLOT;
    endcase
  endfunction

  function automatic logic bank_parent(input logic [IDX_W-1:0] i);
    return (i[IDX_W-1] || (i[IDX_W-1:4] == 4'h5)) && (i[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/sri_gpr_map.sv
module sri_gpr_map
  import sri_pkg::*;
(
  input  logic [GPR_W-1:0]  gidx,
  input  logic [MODE_W-1:0] mode,
  input  logic              wide,
  output logic [PHYS_W-1:0] phys
);
  logic [3:0]        slot;
  logic [PHYS_W-1:0] ident;
  logic              is_pair_reg;
  logic              is_fiq_reg;

  assign slot        = pair_slot(mode);
  assign ident       = PHYS_W'(gidx);
  assign is_pair_reg = (gidx == 4'd13) || (gidx == 4'd14);
  assign is_fiq_reg  = (gidx >= 4'd8) && (gidx <= 4'd14);

  always_comb begin
    phys = ident;
    if (!wide) begin
      if (mode == M_FIQ && is_fiq_reg)
        phys = P_FIQ + PHYS_W'(gidx - 4'd8);
      else if (mode == M_HYP && gidx == 4'd13)
        phys = P_HYP13;
      else if (slot != NO_SLOT && is_pair_reg)
        phys = P_PAIRS + PHYS_W'({slot, 1'b0}) + PHYS_W'(gidx == 4'd14);
    end
  end

  // flat table in 64-bit state (R2)
  always_comb begin
    assert_flat_wide_R2: assert (!wide || phys == ident)
      else $error("wide state remapped a register");
  end

  // banked copies stay inside the banked GPR region (R1)
  always_comb begin
    assert_bank_region_R1: assert (phys == ident || (phys >= P_FIQ && phys <= P_HYP13))
      else $error("gpr bank out of region");
  end
endmodule

// File: rtl/sri_ctx_sel.sv
module sri_ctx_sel
  import sri_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              sp_sel,
  output logic [PHYS_W-1:0] sp_phys,
  output logic [PHYS_W-1:0] status_phys,
  output logic              status_none,
  output logic              mode_bad
);
  logic [LVL_W-1:0] lvl;
  logic [LVL_W-1:0] sp_lvl;
  logic [3:0]       sslot;

  assign lvl      = mode_level(mode);
  assign sslot    = status_slot(mode);
  assign mode_bad = !mode_known(mode);

  always_comb begin
    sp_lvl = lvl;
    if (!sp_sel && lvl != 2'd0) sp_lvl = 2'd0;
  end

  assign sp_phys     = P_SP + PHYS_W'(sp_lvl);
  assign status_none = (sslot == NO_SLOT);
  assign status_phys = status_none ? PHYS_W'(L_STATUS) : P_STATUS + PHYS_W'(sslot);

  // an undefined mode never owns a saved-status copy (R5, R10)
  always_comb begin
    assert_bad_has_none_R10: assert (!mode_bad || status_none)
      else $error("undefined mode got a status slot");
  end

  // stack pointer of level 0 whenever stack-select is clear (R3)
  always_comb begin
    assert_sp0_when_clear_R3: assert (sp_sel || sp_phys == P_SP)
      else $error("stack select clear but not level 0");
  end
endmodule

// File: rtl/sri_shared_res.sv
module sri_shared_res
  import sri_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic              eae,
  input  logic [CSEL_W-1:0] csel,
  input  logic              sec,
  output logic [IDX_W-1:0]  mapped,
  output logic [IDX_W-1:0]  banked,
  output logic              unknown
);
  logic [1:0] off;
  logic       in_range;

  assign off      = idx[1:0];
  assign in_range = (idx[IDX_W-1:4] == L_SHARED_HI);

  always_comb begin
    mapped  = idx;
    unknown = 1'b0;
    if (in_range) begin
      if (idx[3:2] == 2'b00 && off != 2'b11)
        mapped = (eae ? L_ATTR_A : L_REMAP_A) + IDX_W'(off);
      else if (idx[3:2] == 2'b01 && off != 2'b11)
        mapped = (eae ? L_ATTR_B : L_REMAP_B) + IDX_W'(off);
      else if (idx == L_SH_EVF)
        mapped = (csel == CYC_SEL) ? L_CYCFILT : L_EVTYPE;
      else
        unknown = 1'b1;
    end
  end

  always_comb begin
    banked = mapped;
    if (bank_parent(mapped)) banked = mapped + (sec ? 8'd2 : 8'd1);
  end

  // a banked parent always moves by exactly one or two (R8)
  always_comb begin
    assert_bank_step_R8: assert (!bank_parent(mapped) ||
                                 (banked - mapped == 8'd1) || (banked - mapped == 8'd2))
      else $error("bad bank offset");
  end

  // the error flag only rises inside the shared range (R9)
  always_comb begin
    assert_err_in_range_R9: assert (!unknown || (in_range && mapped == idx))
      else $error("shared error outside range");
  end
endmodule

// File: rtl/sysreg_index_resolver.sv
module sysreg_index_resolver
  import sri_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              sp_sel_in,
  input  logic              state64_in,
  input  logic              sec_present_in,
  input  logic              top64_in,
  input  logic              secure_in,
  input  logic              eae_in,
  input  logic [CSEL_W-1:0] ctr_sel_in,
  output logic [PHYS_W-1:0] phys_out,
  output logic              bad_mode_out,
  output logic              no_status_out,
  output logic              mutex_err_out
);
  localparam logic [IDX_W-1:0] GPR_COUNT = IDX_W'(1 << GPR_W);

  logic              sec_eff;
  logic [PHYS_W-1:0] gpr_phys;
  logic [PHYS_W-1:0] sp_phys;
  logic [PHYS_W-1:0] status_phys;
  logic              status_none;
  logic [IDX_W-1:0]  sh_mapped;
  logic [IDX_W-1:0]  sh_banked;
  logic              sh_unknown;
  logic              is_gpr;

  assign sec_eff = sec_present_in && !top64_in && secure_in;
  assign is_gpr  = idx_in < GPR_COUNT;

  sri_gpr_map u_gpr (
    .gidx (idx_in[GPR_W-1:0]),
    .mode (mode_in),
    .wide (state64_in),
    .phys (gpr_phys)
  );

  sri_ctx_sel u_ctx (
    .mode        (mode_in),
    .sp_sel      (sp_sel_in),
    .sp_phys     (sp_phys),
    .status_phys (status_phys),
    .status_none (status_none),
    .mode_bad    (bad_mode_out)
  );

  sri_shared_res u_sh (
    .idx     (idx_in),
    .eae     (eae_in),
    .csel    (ctr_sel_in),
    .sec     (sec_eff),
    .mapped  (sh_mapped),
    .banked  (sh_banked),
    .unknown (sh_unknown)
  );

  always_comb begin
    phys_out      = PHYS_W'(sh_banked);
    no_status_out = 1'b0;
    mutex_err_out = 1'b0;
    if (is_gpr) begin
      phys_out = gpr_phys;
    end else if (idx_in == L_SP_ALIAS) begin
      phys_out = sp_phys;
    end else if (idx_in == L_STATUS) begin
      phys_out      = status_phys;
      no_status_out = status_none;
    end else begin
      mutex_err_out = sh_unknown;
    end
  end

  // a missing saved-status copy falls back to the generic index (R5)
  always_comb begin
    assert_status_fallback_R5: assert (!no_status_out || phys_out == PHYS_W'(L_STATUS))
      else $error("fallback index wrong");
  end

  // stack alias lands in the four stack-pointer slots (R3)
  always_comb begin
    assert_sp_window_R3: assert (idx_in != L_SP_ALIAS ||
                                 (phys_out >= P_SP && phys_out <= P_SP + 9'd3))
      else $error("stack alias outside window");
  end

  // a known saved-status request lands in the ten status slots (R4)
  always_comb begin
    assert_status_window_R4: assert (idx_in != L_STATUS || no_status_out ||
                                     (phys_out >= P_STATUS && phys_out <= P_STATUS + 9'd9))
      else $error("status outside window");
  end

  // shared entries never resolve into the shared range itself unless flagged (R6, R7)
  always_comb begin
    assert_shared_leaves_R6: assert (idx_in[IDX_W-1:4] != L_SHARED_HI || mutex_err_out ||
                                     phys_out[IDX_W-1:4] != L_SHARED_HI)
      else $error("shared entry unresolved");
  end
endmodule

// File: tb/sysreg_index_resolver_bench.sv
module sysreg_index_resolver_bench;
  logic       clk = 1'b0;
  logic [7:0] idx;
  logic [4:0] mode;
  logic       sp_sel, st64, secp, top64, sec, eae;
  logic [4:0] csel;
  logic [8:0] phys;
  logic       bad, nostat, merr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysreg_index_resolver u_sysreg_index_resolver (
    .idx_in(idx), .mode_in(mode), .sp_sel_in(sp_sel), .state64_in(st64),
    .sec_present_in(secp), .top64_in(top64), .secure_in(sec), .eae_in(eae),
    .ctr_sel_in(csel), .phys_out(phys), .bad_mode_out(bad),
    .no_status_out(nostat), .mutex_err_out(merr)
  );

  function automatic int lvl_of(input int m);
    if (m == 'h04 || m == 'h05 || m == 'h11 || m == 'h12 || m == 'h13 ||
        m == 'h17 || m == 'h1B || m == 'h1F) return 1;
    if (m == 'h08 || m == 'h09 || m == 'h1A) return 2;
    if (m == 'h0C || m == 'h0D || m == 'h16) return 3;
    return 0;
  endfunction

  function automatic bit known(input int m);
    int codes[16] = '{'h00,'h04,'h05,'h08,'h09,'h0C,'h0D,'h10,'h11,'h12,'h13,'h16,'h17,'h1A,'h1B,'h1F};
    foreach (codes[k]) if (codes[k] == m) return 1;
    return 0;
  endfunction

  function automatic int status_of(input int m);
    case (m)
      'h04, 'h05: return 'h120;
      'h08, 'h09: return 'h121;
      'h0C, 'h0D: return 'h122;
      'h11: return 'h123;
      'h12: return 'h124;
      'h13: return 'h125;
      'h16: return 'h126;
      'h17: return 'h127;
      'h1A: return 'h128;
      'h1B: return 'h129;
      default: return -1;
    endcase
  endfunction

  function automatic int bank(input int i, input bit s);
    bit parent = ((i >= 'h80) || (i >= 'h50 && i <= 'h5F)) && (i % 4 == 0);
    if (!parent) return i;
    return s ? i + 2 : i + 1;
  endfunction

  function automatic int exp_phys(input int i, input int m);
    bit s = secp && !top64 && sec;
    int e;
    if (i < 16) begin
      if (st64) return i;
      if (m == 'h11 && i >= 8 && i <= 14) return 'h100 + i - 8;
      if (m == 'h1A && i == 13) return 'h112;
      if (i == 13 || i == 14) begin
        case (m)
          'h12: return 'h108 + i - 13;
          'h13: return 'h10A + i - 13;
          'h17: return 'h10C + i - 13;
          'h1B: return 'h10E + i - 13;
          'h16: return 'h110 + i - 13;
          default: return i;
        endcase
      end
      return i;
    end
    if (i == 'h20) begin
      e = lvl_of(m);
      if (!sp_sel) e = 0;
      return 'h118 + e;
    end
    if (i == 'h30) return (status_of(m) < 0) ? 'h30 : status_of(m);
    if (i >= 'h40 && i <= 'h42) return bank((eae ? 'h54 : 'h50) + i - 'h40, s);
    if (i >= 'h44 && i <= 'h46) return bank((eae ? 'h5C : 'h58) + i - 'h44, s);
    if (i == 'h48) return (csel == 31) ? 'h61 : 'h60;
    return bank(i, s);
  endfunction

  function automatic string tag_of(input int i);
    if (i < 16) return st64 ? "R2" : "R1";
    if (i == 'h20) return "R3";
    if (i == 'h30) return "R4";
    if (i >= 'h40 && i <= 'h47 && (i % 4) != 3) return "R6";
    if (i == 'h48) return "R7";
    if (i >= 'h40 && i <= 'h4F) return "R9";
    if (((i >= 'h80) || (i >= 'h50 && i <= 'h5F)) && (i % 4 == 0)) return "R8";
    return "R11";
  endfunction

  task automatic apply_check(input int i, input int m);
    int ep;
    bit ew, ee, eb;
    @(negedge clk);
    idx = 8'(i); mode = 5'(m);
    @(posedge clk); #1;
    ep = exp_phys(i, m);
    ew = (i == 'h30) && (status_of(m) < 0);
    ee = (i >= 'h40 && i <= 'h4F) && !((i <= 'h46 && (i % 4) != 3) || i == 'h48);
    eb = !known(m);
    checks++;
    if (int'(phys) != ep) begin
      errors++;
      $display("FAIL %s idx=%h mode=%h phys actual=%h expected=%h", tag_of(i), i, m, phys, ep);
    end
    checks++;
    if (nostat != ew) begin
      errors++;
      $display("FAIL R5 idx=%h mode=%h no_status actual=%0d expected=%0d", i, m, nostat, ew);
    end
    checks++;
    if (merr != ee) begin
      errors++;
      $display("FAIL R9 idx=%h mutex_err actual=%0d expected=%0d", i, merr, ee);
    end
    checks++;
    if (bad != eb) begin
      errors++;
      $display("FAIL R10 mode=%h bad_mode actual=%0d expected=%0d", m, bad, eb);
    end
  endtask

  task automatic set_ctl(input int c);
    sp_sel = c[0]; st64 = c[1]; secp = c[2]; top64 = c[3]; sec = c[4]; eae = c[5];
  endtask

  initial begin
    int seed = 32'h5EED_1234;
    int focus[12] = '{'h08, 'h0D, 'h0E, 'h0C, 'h20, 'h30, 'h40, 'h42, 'h44, 'h48, 'h50, 'h80};
    void'($urandom(seed));
    idx = 0; mode = 5'h10; set_ctl(0); csel = 0;
    // reset-like quiet state: user mode, index 0
    @(posedge clk); #1;
    checks++;
    if (phys != 9'h000 || bad || nostat || merr) begin
      errors++;
      $display("FAIL R1 idle phys actual=%h expected=000", phys);
    end
    // directed: every mode with every control combination on the deciding indices
    foreach (focus[f])
      for (int m = 0; m < 32; m++)
        for (int c = 0; c < 64; c++) begin
          set_ctl(c);
          csel = (c % 2 == 0) ? 5'd31 : 5'($urandom_range(0, 30));
          apply_check(focus[f], m);
        end
    // sweep of the whole index space in every mode, random controls
    for (int m = 0; m < 32; m++)
      for (int i = 0; i < 256; i++) begin
        set_ctl($urandom_range(0, 63));
        csel = ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom);
        apply_check(i, m);
      end
    // R8: secure state needs all three qualifiers
    for (int c = 0; c < 8; c++) begin
      set_ctl(0); secp = c[0]; top64 = c[1]; sec = c[2];
      apply_check('hC4, 'h13);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule